// File: doc/BRIEF.md
# Multi-Port Set/Clear GPIO Controller

This block is a general-purpose pin controller with four ports. It sits behind a simple synchronous register bus: a byte address, a write strobe, a 32-bit write word and a registered 32-bit read word. Ports 0, 1 and 2 are bidirectional banks. Each pin has a direction bit and an output level bit, and each pad input is read back through an input state register. Port 2 also carries a bank of mux-select bits that leave the block on their own output.

Port 3 is a mixed port. It has six bidirectional pins, a group of input-only pins and 24 output-only pins. All of them share one input state register and one output register, at fixed bit positions that are not contiguous. The direction bits of the six bidirectional pins live in the port 2 direction register.

Software never writes a state register directly. A 1 written to a set register raises the matching stored bits, and a 1 written to a clear register lowers them. The result is then read back from a separate state register. Every pad input is passed through a two-flop synchronizer before software can see it.

Top module: `pinbank_ctrl`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, every direction bit, output level and mux bit is 0 and bus_rdata is 0. As a result, every *_oe, *_out, p2_mux and p3_gpo output is 0.
- R2: A write to a set register ORs the write word into the stored state, and a write to a clear register removes the written 1 bits. Bits written as 0 keep their value. The new state appears at the outputs right after the clock edge that samples the write.
- R3: A direction bit of 1 drives the pin's output enable high (output), and 0 makes the pin an input. Writes to addresses other than a port's direction set and clear registers never change that port's enables.
- R4: Ports 0 (8 pins) and 1 (24 pins) start at 0x40 and 0x60. Each uses these offsets from its start: input state +0x00, output set +0x04, output clear +0x08, output state +0x0C, direction set +0x10, direction clear +0x14 and direction state +0x18. Pin n is bit n.
- R5: Port 2 has 13 pins on bits 0–12, with no output state readback. Its offsets are: direction set/clear/state at 0x10/0x14/0x18, input state at 0x1C, output set/clear at 0x20/0x24, and mux set/clear/state at 0x28/0x2C/0x30. The mux state appears on p2_mux.
- R6: Port 3 bidirectional pin n (n = 0..5) takes its output level from bit 25+n of the port 3 output registers. It takes its direction from bit 25+n of the port 2 direction registers.
- R7: The port 3 output registers are set at 0x004, cleared at 0x008 and read as state at 0x00C. Output-only pin k (k = 0..23) is bit k of those registers.
- R8: The port 3 input state register at 0x000 carries the following. Bidirectional pins 0–4 appear on bits 10–14 and pin 5 on bit 24. Input-only pad bits appear on every other position in 0–27, and bits 28–31 read 0.
- R9: Each pad input needs two clock edges to reach its input state register. With the address held, a pad change made before edge e1 is seen in bus_rdata after edge e3 and not after edge e2.
- R10: A read of a set register, a clear register or an unmapped address returns 0. State bits that have no pin always read 0 and drive nothing.
- R11: bus_rdata is registered: it shows the register addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write word |
| bus_rdata | output | 32 | Registered read word |
| p0_in | input | 8 | Port 0 pad inputs |
| p0_out | output | 8 | Port 0 output levels |
| p0_oe | output | 8 | Port 0 output enables |
| p1_in | input | 24 | Port 1 pad inputs |
| p1_out | output | 24 | Port 1 output levels |
| p1_oe | output | 24 | Port 1 output enables |
| p2_in | input | 13 | Port 2 pad inputs |
| p2_out | output | 13 | Port 2 output levels |
| p2_oe | output | 13 | Port 2 output enables |
| p2_mux | output | 8 | Port 2 mux-select state |
| p3_io_in | input | 6 | Port 3 bidirectional pad inputs |
| p3_io_out | output | 6 | Port 3 bidirectional output levels |
| p3_io_oe | output | 6 | Port 3 bidirectional output enables |
| p3_gpi | input | 28 | Port 3 input-only pads (positions 10–14 and 24 unused) |
| p3_gpo | output | 24 | Port 3 output-only levels |

## Verification
Two pin groups can change in the same cycle from one write. A single word written to the port 2 direction set or clear register updates the port 2 enables and the port 3 bidirectional enables at once. A word written to the port 3 output registers likewise moves the output-only pins and the bidirectional levels together. The bench writes words that hit both fields, plus bits that belong to neither. It then checks, at the same sample, that both output groups changed exactly as the arithmetic model predicts and that the spare bits read back as 0.

// File: rtl/pinbank_pkg.sv
package pinbank_pkg;
  localparam int DATA_W = 32;

  // port 3 register block
  localparam logic [7:0] A3_IN      = 8'h00;
  localparam logic [7:0] A3_OSET    = 8'h04;
  localparam logic [7:0] A3_OCLR    = 8'h08;
  localparam logic [7:0] A3_OSTATE  = 8'h0C;
  // port 2 register block
  localparam logic [7:0] A2_DSET    = 8'h10;
  localparam logic [7:0] A2_DCLR    = 8'h14;
  localparam logic [7:0] A2_DSTATE  = 8'h18;
  localparam logic [7:0] A2_IN      = 8'h1C;
  localparam logic [7:0] A2_OSET    = 8'h20;
  localparam logic [7:0] A2_OCLR    = 8'h24;
  localparam logic [7:0] A2_MSET    = 8'h28;
  localparam logic [7:0] A2_MCLR    = 8'h2C;
  localparam logic [7:0] A2_MSTATE  = 8'h30;
  // uniform bidirectional banks
  localparam logic [7:0] BANK0_BASE = 8'h40;
  localparam logic [7:0] BANK1_BASE = 8'h60;
  localparam logic [7:0] OFS_IN     = 8'h00;
  localparam logic [7:0] OFS_OSET   = 8'h04;
  localparam logic [7:0] OFS_OCLR   = 8'h08;
  localparam logic [7:0] OFS_OSTATE = 8'h0C;
  localparam logic [7:0] OFS_DSET   = 8'h10;
  localparam logic [7:0] OFS_DCLR   = 8'h14;
  localparam logic [7:0] OFS_DSTATE = 8'h18;

  // port 3 bidirectional pins: level and direction field start
  localparam int P3_IO_LSB = 25;

  function automatic logic [DATA_W-1:0] low_mask(input int w);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < w) m[i] = 1'b1;
    end
    return m;
  endfunction

  // input-register bit that carries port 3 bidirectional pin n
  function automatic int p3_rd_pos(input int n);
    return (n < 5) ? (10 + n) : 24;
  endfunction

  function automatic logic [DATA_W-1:0] p3_rd_mask(input int nio);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int n = 0; n < nio; n++) m[p3_rd_pos(n)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pb_sync.sv
module pb_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/pb_setclr_reg.sv
module pb_setclr_reg #(
  parameter int           W    = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] set_bits;
  logic [W-1:0] clr_bits;

  assign set_bits = set_stb ? wdata : '0;
  assign clr_bits = clr_stb ? wdata : '0;

  // clear is applied after set, so a bit both set and cleared ends at 0
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (q | set_bits) & ~clr_bits & KEEP;
  end
endmodule

// File: rtl/pb_bidir_port.sv
module pb_bidir_port
  import pinbank_pkg::*;
#(
  parameter int         W      = 8,
  parameter int         AW     = 8,
  parameter logic [7:0] BASE   = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [AW-1:0] A_IN  = AW'(BASE + OFS_IN);
  localparam logic [AW-1:0] A_OS  = AW'(BASE + OFS_OSET);
  localparam logic [AW-1:0] A_OC  = AW'(BASE + OFS_OCLR);
  localparam logic [AW-1:0] A_OST = AW'(BASE + OFS_OSTATE);
  localparam logic [AW-1:0] A_DS  = AW'(BASE + OFS_DSET);
  localparam logic [AW-1:0] A_DC  = AW'(BASE + OFS_DCLR);
  localparam logic [AW-1:0] A_DST = AW'(BASE + OFS_DSTATE);

  logic [W-1:0] in_q;
  logic         unused_wdata;

  assign unused_wdata = ^wdata;

  pb_sync #(.W(W)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(in_q)
  );

  pb_setclr_reg #(.W(W)) u_out (
    .clk(clk), .rst(rst),
    .set_stb(we && addr == A_OS),
    .clr_stb(we && addr == A_OC),
    .wdata(wdata[W-1:0]),
    .q(pad_out)
  );

  pb_setclr_reg #(.W(W)) u_dir (
    .clk(clk), .rst(rst),
    .set_stb(we && addr == A_DS),
    .clr_stb(we && addr == A_DC),
    .wdata(wdata[W-1:0]),
    .q(pad_oe)
  );

  always_comb begin
    rd_data = '0;
    if (addr == A_IN)  rd_data = DATA_W'(in_q);
    if (addr == A_OST) rd_data = DATA_W'(pad_out);
    if (addr == A_DST) rd_data = DATA_W'(pad_oe);
  end
endmodule

// File: rtl/pinbank_ctrl.sv
module pinbank_ctrl
  import pinbank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int P0_W     = 8,
  parameter int P1_W     = 24,
  parameter int P2_W     = 13,
  parameter int MUX_W    = 8,
  parameter int P3_IO_W  = 6,
  parameter int P3_GPI_W = 28,
  parameter int P3_GPO_W = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  input  logic [P0_W-1:0]     p0_in,
  output logic [P0_W-1:0]     p0_out,
  output logic [P0_W-1:0]     p0_oe,
  input  logic [P1_W-1:0]     p1_in,
  output logic [P1_W-1:0]     p1_out,
  output logic [P1_W-1:0]     p1_oe,
  input  logic [P2_W-1:0]     p2_in,
  output logic [P2_W-1:0]     p2_out,
  output logic [P2_W-1:0]     p2_oe,
  output logic [MUX_W-1:0]    p2_mux,
  input  logic [P3_IO_W-1:0]  p3_io_in,
  output logic [P3_IO_W-1:0]  p3_io_out,
  output logic [P3_IO_W-1:0]  p3_io_oe,
  input  logic [P3_GPI_W-1:0] p3_gpi,
  output logic [P3_GPO_W-1:0] p3_gpo
);
  localparam logic [DATA_W-1:0] IO_FIELD  = low_mask(P3_IO_W) << P3_IO_LSB;
  localparam logic [DATA_W-1:0] DIR2_KEEP = low_mask(P2_W) | IO_FIELD;
  localparam logic [DATA_W-1:0] OUT3_KEEP = low_mask(P3_GPO_W) | IO_FIELD;
  localparam logic [DATA_W-1:0] IO_RDPOS  = p3_rd_mask(P3_IO_W);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  // ---------------- ports 0 and 1: uniform banks ----------------
  logic [DATA_W-1:0] rd_p0, rd_p1;

  pb_bidir_port #(.W(P0_W), .AW(ADDR_W), .BASE(BANK0_BASE)) u_bank0 (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .pad_in(p0_in), .pad_out(p0_out), .pad_oe(p0_oe), .rd_data(rd_p0)
  );

  pb_bidir_port #(.W(P1_W), .AW(ADDR_W), .BASE(BANK1_BASE)) u_bank1 (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .pad_in(p1_in), .pad_out(p1_out), .pad_oe(p1_oe), .rd_data(rd_p1)
  );

  // ---------------- port 2 ----------------
  logic [DATA_W-1:0] dir2_q;
  logic [P2_W-1:0]   in2_q;

  pb_setclr_reg #(.W(DATA_W), .KEEP(DIR2_KEEP)) u_dir2 (
    .clk(clk), .rst(rst),
    .set_stb(bus_we && hit(bus_addr, A2_DSET)),
    .clr_stb(bus_we && hit(bus_addr, A2_DCLR)),
    .wdata(bus_wdata), .q(dir2_q)
  );

  pb_setclr_reg #(.W(P2_W)) u_out2 (
    .clk(clk), .rst(rst),
    .set_stb(bus_we && hit(bus_addr, A2_OSET)),
    .clr_stb(bus_we && hit(bus_addr, A2_OCLR)),
    .wdata(bus_wdata[P2_W-1:0]), .q(p2_out)
  );

  pb_setclr_reg #(.W(MUX_W)) u_mux2 (
    .clk(clk), .rst(rst),
    .set_stb(bus_we && hit(bus_addr, A2_MSET)),
    .clr_stb(bus_we && hit(bus_addr, A2_MCLR)),
    .wdata(bus_wdata[MUX_W-1:0]), .q(p2_mux)
  );

  pb_sync #(.W(P2_W)) u_sync2 (.clk(clk), .rst(rst), .d(p2_in), .q(in2_q));

  assign p2_oe    = dir2_q[P2_W-1:0];
  assign p3_io_oe = dir2_q[P3_IO_LSB +: P3_IO_W];

  // ---------------- port 3: mixed classes ----------------
  logic [DATA_W-1:0]   out3_q;
  logic [P3_IO_W-1:0]  io3_q;
  logic [P3_GPI_W-1:0] gpi3_q;
  logic [DATA_W-1:0]   in3_word;
  logic                unused_gpi;

  pb_setclr_reg #(.W(DATA_W), .KEEP(OUT3_KEEP)) u_out3 (
    .clk(clk), .rst(rst),
    .set_stb(bus_we && hit(bus_addr, A3_OSET)),
    .clr_stb(bus_we && hit(bus_addr, A3_OCLR)),
    .wdata(bus_wdata), .q(out3_q)
  );

  pb_sync #(.W(P3_IO_W))  u_sync3io  (.clk(clk), .rst(rst), .d(p3_io_in), .q(io3_q));
  pb_sync #(.W(P3_GPI_W)) u_sync3gpi (.clk(clk), .rst(rst), .d(p3_gpi),   .q(gpi3_q));

  assign p3_gpo    = out3_q[P3_GPO_W-1:0];
  assign p3_io_out = out3_q[P3_IO_LSB +: P3_IO_W];

  // input-only bits fill the positions the bidirectional pins leave free
  always_comb begin
    in3_word = DATA_W'(gpi3_q) & ~IO_RDPOS;
    for (int n = 0; n < P3_IO_W; n++) begin
      in3_word[p3_rd_pos(n)] = io3_q[n];
    end
  end

  assign unused_gpi = ^(DATA_W'(gpi3_q) & IO_RDPOS);

  // ---------------- read decode ----------------
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    rd_word = rd_p0 | rd_p1;
    if (hit(bus_addr, A3_IN))     rd_word = in3_word;
    if (hit(bus_addr, A3_OSTATE)) rd_word = out3_q;
    if (hit(bus_addr, A2_DSTATE)) rd_word = dir2_q;
    if (hit(bus_addr, A2_IN))     rd_word = DATA_W'(in2_q);
    if (hit(bus_addr, A2_MSTATE)) rd_word = DATA_W'(p2_mux);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_word;
  end
endmodule

// File: rtl/pinbank_ctrl_chk.sv
module pinbank_ctrl_chk
  import pinbank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int P0_W     = 8,
  parameter int P1_W     = 24,
  parameter int P2_W     = 13,
  parameter int MUX_W    = 8,
  parameter int P3_IO_W  = 6,
  parameter int P3_GPI_W = 28,
  parameter int P3_GPO_W = 24
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [P0_W-1:0]     p0_in,
  input logic [P0_W-1:0]     p0_out,
  input logic [P0_W-1:0]     p0_oe,
  input logic [P1_W-1:0]     p1_in,
  input logic [P1_W-1:0]     p1_out,
  input logic [P1_W-1:0]     p1_oe,
  input logic [P2_W-1:0]     p2_in,
  input logic [P2_W-1:0]     p2_out,
  input logic [P2_W-1:0]     p2_oe,
  input logic [MUX_W-1:0]    p2_mux,
  input logic [P3_IO_W-1:0]  p3_io_in,
  input logic [P3_IO_W-1:0]  p3_io_out,
  input logic [P3_IO_W-1:0]  p3_io_oe,
  input logic [P3_GPI_W-1:0] p3_gpi,
  input logic [P3_GPO_W-1:0] p3_gpo
);
  logic unused_chk;
  assign unused_chk = ^{p0_in, p1_in, p1_out, p2_in, p2_out, p3_io_in, p3_io_out, p3_gpi};

  localparam logic [ADDR_W-1:0] C0_OSET = ADDR_W'(BANK0_BASE + OFS_OSET);
  localparam logic [ADDR_W-1:0] C0_OCLR = ADDR_W'(BANK0_BASE + OFS_OCLR);
  localparam logic [ADDR_W-1:0] C1_DSET = ADDR_W'(BANK1_BASE + OFS_DSET);
  localparam logic [ADDR_W-1:0] C1_DCLR = ADDR_W'(BANK1_BASE + OFS_DCLR);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (p0_oe == '0 && p1_oe == '0 && p2_oe == '0 && p3_io_oe == '0 &&
                    p0_out == '0 && p3_gpo == '0 && p2_mux == '0 && bus_rdata == '0));

  // R2
  bank0_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == C0_OSET) |=> p0_out == ($past(p0_out) | $past(bus_wdata[P0_W-1:0])));

  // R2
  bank0_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == C0_OCLR) |=> p0_out == ($past(p0_out) & ~$past(bus_wdata[P0_W-1:0])));

  // R3
  bank1_oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && (bus_addr == C1_DSET || bus_addr == C1_DCLR)) |=> $stable(p1_oe));

  // R6
  p3_dir_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == ADDR_W'(A2_DCLR)) |=>
      p3_io_oe == ($past(p3_io_oe) & ~$past(bus_wdata[P3_IO_LSB +: P3_IO_W])));

  // R10
  set_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == C0_OSET || bus_addr == ADDR_W'(A3_OCLR)) |=> bus_rdata == '0);
endmodule

bind pinbank_ctrl pinbank_ctrl_chk #(
  .ADDR_W(ADDR_W), .P0_W(P0_W), .P1_W(P1_W), .P2_W(P2_W), .MUX_W(MUX_W),
  .P3_IO_W(P3_IO_W), .P3_GPI_W(P3_GPI_W), .P3_GPO_W(P3_GPO_W)
) u_chk (.*);

// File: tb/sim_pinbank_ctrl.sv
`timescale 1ns/1ps
module sim_pinbank_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  p0_in = '0, p0_out, p0_oe;
  logic [23:0] p1_in = '0, p1_out, p1_oe;
  logic [12:0] p2_in = '0, p2_out, p2_oe;
  logic [7:0]  p2_mux;
  logic [5:0]  p3_io_in = '0, p3_io_out, p3_io_oe;
  logic [27:0] p3_gpi = '0;
  logic [23:0] p3_gpo;

  always #2 clk = ~clk;

  pinbank_ctrl u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .p0_in(p0_in), .p0_out(p0_out), .p0_oe(p0_oe),
    .p1_in(p1_in), .p1_out(p1_out), .p1_oe(p1_oe),
    .p2_in(p2_in), .p2_out(p2_out), .p2_oe(p2_oe), .p2_mux(p2_mux),
    .p3_io_in(p3_io_in), .p3_io_out(p3_io_out), .p3_io_oe(p3_io_oe),
    .p3_gpi(p3_gpi), .p3_gpo(p3_gpo)
  );

  int checks = 0;
  int fails  = 0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] msk(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
  endfunction

  function automatic logic [31:0] nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed ^ (seed >> 13);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  function automatic logic [31:0] bank_out(input logic [7:0] base);
    return (base == 8'h40) ? 32'(p0_out) : 32'(p1_out);
  endfunction
  function automatic logic [31:0] bank_oe(input logic [7:0] base);
    return (base == 8'h40) ? 32'(p0_oe) : 32'(p1_oe);
  endfunction

  // expected port 3 input word from pad values
  function automatic logic [31:0] p3_exp(input logic [27:0] g, input logic [5:0] io);
    logic [31:0] e;
    e = {4'b0, g} & ~(32'h0000_7C00 | 32'h0100_0000);
    e = e | (32'(io[4:0]) << 10) | (32'(io[5]) << 24);
    return e;
  endfunction

  task automatic sweep_bank(input logic [7:0] base, input int w);
    logic [31:0] mo, md, r, p, q, m;
    m = msk(w); mo = '0; md = '0;
    for (int i = 0; i < w; i++) begin
      wr(base + 8'h04, 32'd1 << i); mo |= (32'd1 << i);
      chk("R2 bank set walk", bank_out(base), mo);
      wr(base + 8'h10, 32'd1 << i); md |= (32'd1 << i);
      chk("R3 bank dir set walk", bank_oe(base), md);
    end
    for (int i = 0; i < w; i += 3) begin
      wr(base + 8'h08, 32'd1 << i); mo &= ~(32'd1 << i);
      chk("R2 bank clear walk", bank_out(base), mo);
      wr(base + 8'h14, 32'd1 << i); md &= ~(32'd1 << i);
      chk("R3 bank dir clear walk", bank_oe(base), md);
    end
    for (int k = 0; k < 12; k++) begin
      p = nxt(); q = nxt();
      wr(base + 8'h04, p); mo = (mo | p) & m;
      wr(base + 8'h08, q); mo = mo & ~q;
      wr(base + 8'h14, p); md = md & ~p;
      wr(base + 8'h10, q); md = (md | q) & m;
      chk("R2 bank pattern out", bank_out(base), mo);
      chk("R3 bank pattern oe", bank_oe(base), md);
      rd(base + 8'h0C, r); chk("R4 R10 bank out readback", r, mo);
      rd(base + 8'h18, r); chk("R4 R10 bank dir readback", r, md);
      rd(base + 8'h04, r); chk("R10 set reg reads zero", r, 32'd0);
      rd(base + 8'h14, r); chk("R10 clear reg reads zero", r, 32'd0);
    end
    for (int k = 0; k < 8; k++) begin
      p = nxt() & m;
      if (base == 8'h40) p0_in = p[7:0]; else p1_in = p[23:0];
      repeat (2) @(negedge clk);
      rd(base, r); chk("R4 bank input readback", r, p);
    end
  endtask

  logic [31:0] r, p, q, m_dir2, m_out3, m_mux;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 oe idle in reset", {p0_oe, p1_oe}, 32'd0);
    rst = 1'b0;
    chk("R1 out idle", {p0_out, p1_out}, 32'd0);
    chk("R1 p3 idle", {p3_gpo, p2_mux}, 32'd0);
    chk("R1 p2/p3 oe idle", {p2_oe, p3_io_oe, p3_io_out}, 32'd0);
    rd(8'h4C, r); chk("R1 bank0 out state", r, 32'd0);
    rd(8'h18, r); chk("R1 p2 dir state", r, 32'd0);
    rd(8'h0C, r); chk("R1 p3 out state", r, 32'd0);

    // R9 / R11: synchronizer and registered read latency
    bus_addr = 8'h40;
    @(negedge clk); p0_in = 8'hA5;
    @(negedge clk); chk("R9 after e1 old", bus_rdata, 32'd0);
    @(negedge clk); chk("R9 after e2 old", bus_rdata, 32'd0);
    @(negedge clk); chk("R9 R11 after e3 new", bus_rdata, 32'hA5);
    bus_addr = 8'h4C;
    @(negedge clk); chk("R11 address switch", bus_rdata, 32'd0);

    sweep_bank(8'h40, 8);
    sweep_bank(8'h60, 24);

    // port 2 and port 3 direction share one register
    m_dir2 = '0;
    for (int k = 0; k < 16; k++) begin
      p = nxt(); q = nxt();
      wr(8'h10, p); m_dir2 = (m_dir2 | p) & 32'h7E00_1FFF;
      chk("R3 R5 p2 oe after dir set", 32'(p2_oe), m_dir2 & 32'h1FFF);
      chk("R6 p3 oe same write", 32'(p3_io_oe), (m_dir2 >> 25) & 32'h3F);
      wr(8'h14, q); m_dir2 = m_dir2 & ~q;
      chk("R5 p2 oe after dir clr", 32'(p2_oe), m_dir2 & 32'h1FFF);
      chk("R6 p3 oe same clear", 32'(p3_io_oe), (m_dir2 >> 25) & 32'h3F);
      rd(8'h18, r); chk("R5 R10 dir2 readback", r, m_dir2);
    end

    // port 2 levels and mux
    for (int i = 0; i < 13; i++) begin
      wr(8'h20, 32'd1 << i);
      chk("R5 p2 out set walk", 32'(p2_out), msk(i + 1));
    end
    wr(8'h24, 32'h0000_0AAA);
    chk("R5 p2 out clear", 32'(p2_out), 32'h1555);
    m_mux = '0;
    for (int k = 0; k < 8; k++) begin
      p = nxt(); q = nxt();
      wr(8'h28, p); wr(8'h2C, q); m_mux = ((m_mux | p) & ~q) & 32'hFF;
      chk("R5 mux output", 32'(p2_mux), m_mux);
      rd(8'h30, r); chk("R5 mux readback", r, m_mux);
    end
    for (int i = 0; i < 13; i++) begin
      p2_in = 13'(32'd1 << i);
      repeat (2) @(negedge clk);
      rd(8'h1C, r); chk("R5 p2 input walk", r, 32'd1 << i);
    end

    // port 3 outputs: output-only and bidirectional levels together
    m_out3 = '0;
    for (int i = 0; i < 32; i++) begin
      wr(8'h04, 32'd1 << i);
      if (i < 24 || (i >= 25 && i <= 30)) m_out3 |= (32'd1 << i);
      chk("R7 gpo walk", 32'(p3_gpo), m_out3 & 32'hFF_FFFF);
      chk("R6 io level walk", 32'(p3_io_out), (m_out3 >> 25) & 32'h3F);
      rd(8'h0C, r); chk("R7 R10 p3 out readback", r, m_out3);
    end
    for (int k = 0; k < 10; k++) begin
      q = nxt(); p = nxt();
      wr(8'h08, q); m_out3 &= ~q;
      wr(8'h04, p); m_out3 = (m_out3 | p) & 32'h7EFF_FFFF;
      chk("R7 gpo pattern", 32'(p3_gpo), m_out3 & 32'hFF_FFFF);
      chk("R6 io level pattern", 32'(p3_io_out), (m_out3 >> 25) & 32'h3F);
      rd(8'h08, r); chk("R10 p3 clear reads zero", r, 32'd0);
    end

    // port 3 input register packing
    for (int i = 0; i < 28; i++) begin
      p3_gpi = 28'(32'd1 << i); p3_io_in = '0;
      repeat (2) @(negedge clk);
      rd(8'h00, r); chk("R8 gpi walk", r, p3_exp(p3_gpi, p3_io_in));
    end
    for (int i = 0; i < 6; i++) begin
      p3_gpi = '0; p3_io_in = 6'(32'd1 << i);
      repeat (2) @(negedge clk);
      rd(8'h00, r); chk("R8 io readback walk", r, p3_exp(p3_gpi, p3_io_in));
    end
    for (int k = 0; k < 8; k++) begin
      p = nxt();
      p3_gpi = p[27:0]; p3_io_in = p[31:26];
      repeat (2) @(negedge clk);
      rd(8'h00, r); chk("R8 mixed input", r, p3_exp(p3_gpi, p3_io_in));
    end

    // unmapped addresses
    rd(8'h34, r); chk("R10 unmapped 0x34", r, 32'd0);
    rd(8'h3C, r); chk("R10 unmapped 0x3C", r, 32'd0);
    rd(8'h5C, r); chk("R10 unmapped 0x5C", r, 32'd0);
    rd(8'h7C, r); chk("R10 unmapped 0x7C", r, 32'd0);
    rd(8'hF0, r); chk("R10 unmapped 0xF0", r, 32'd0);
    rd(8'h2C, r); chk("R10 mux clear reads zero", r, 32'd0);

    // R1 reset again after activity
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R1 re-reset oe", {p0_oe, p1_oe}, 32'd0);
    chk("R1 re-reset p3", {p3_gpo, p2_mux}, 32'd0);
    chk("R1 re-reset p2", {p2_oe, p3_io_oe, p3_io_out}, 32'd0);
    chk("R1 re-reset rdata", bus_rdata, 32'd0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule